// File: doc/BRIEF.md
# Instruction Decode Stage

This block is the decode step of a five-stage pipelined processor. Each cycle it takes the fetched instruction word and its next-PC value. It turns the 6-bit opcode into nine control bits, reads two source registers, sign-extends the 16-bit immediate, and captures all of this in the pipeline register that feeds the execute stage. The register file inside the block is written from the write-back stage through a dedicated write port.

The nine control bits are kept in three groups. The write-back group is `{reg_wr, mem_to_reg}`. The memory group is `{branch, mem_rd, mem_wr}`. The execute group is `{dst_sel, alu_op[1:0], alu_imm}`. Each group leaves the block on its own port. The block does no forwarding and no stall detection, and it does not select the write-back data.

Top module: `dec_stage`

## Requirements
- R1: While `rst_n` is low, every `ex_*` output is zero.
- R2: Opcode 000000 (instruction bits [31:26]) registers wb=2'b10, mem=3'b000, ex=4'b1100.
- R3: Opcode 100011 (load) registers wb=2'b11, mem=3'b010, ex=4'b0001.
- R4: Opcode 101011 (store) registers wb=2'b00, mem=3'b001, ex=4'b0001.
- R5: Opcode 000100 (branch) registers wb=2'b00, mem=3'b100, ex=4'b0010.
- R6: Opcode 100000 (no-op) and every other opcode not listed above register all-zero control. At most one memory control bit is ever set.
- R7: Bits [25:21] address the first read port and bits [20:16] address the second. The values read appear on `ex_rs_val` and `ex_rt_val` one clock later.
- R8: When `wb_we` is high at a rising edge, `wb_data` is stored at `wb_addr`. Later reads of that register return the stored value.
- R9: A read of the register being written in the same cycle returns the incoming `wb_data`.
- R10: Register 0 always reads zero. A write to it has no effect, whether the read is in the same cycle or later.
- R11: `ex_imm` is bits [15:0] sign-extended to 32 bits, one clock later.
- R12: `ex_npc`, `ex_rt_idx` (bits [20:16]) and `ex_rd_idx` (bits [15:11]) copy their sources one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_instr | input | 32 | Instruction word from the fetch register |
| ifid_npc | input | 32 | Next-PC value from the fetch register |
| wb_we | input | 1 | Register write enable from write-back |
| wb_addr | input | 5 | Register write address |
| wb_data | input | 32 | Register write data |
| ex_wb_ctl | output | 2 | Registered write-back control group |
| ex_mem_ctl | output | 3 | Registered memory control group |
| ex_ex_ctl | output | 4 | Registered execute control group |
| ex_npc | output | 32 | Registered next-PC |
| ex_rs_val | output | 32 | Registered first read value |
| ex_rt_val | output | 32 | Registered second read value |
| ex_imm | output | 32 | Registered sign-extended immediate |
| ex_rt_idx | output | 5 | Registered instruction bits [20:16] |
| ex_rd_idx | output | 5 | Registered instruction bits [15:11] |

## Verification
The decoder is driven with each of the four recognised opcodes, the no-op code and an unlisted code. These patterns separate a per-group error from a bit misplaced inside a group, and they show that the fallback is really zero. The register file is exercised three ways: a plain write followed by a read, a write and a read of the same register in one cycle, and writes aimed at register 0. Together these tell a missing bypass apart from a missing write, and an unprotected r0 apart from a correct one. Immediates with the top bit set and clear show whether sign extension works. Distinct field values then show whether the two destination indices have been swapped.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int unsigned XLEN   = 32;
    localparam int unsigned RIDX_W = 5;
    localparam int unsigned OP_W   = 6;
    localparam int unsigned IMM_W  = 16;

    localparam logic [OP_W-1:0] OP_ALU   = 6'b000000;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_NOP   = 6'b100000;

    typedef struct packed {
        logic reg_wr;
        logic mem_to_reg;
    } wb_grp_t;

    typedef struct packed {
        logic branch;
        logic mem_rd;
        logic mem_wr;
    } mem_grp_t;

    typedef struct packed {
        logic       dst_sel;
        logic [1:0] alu_op;
        logic       alu_imm;
    } ex_grp_t;

    typedef struct packed {
        wb_grp_t  wb;
        mem_grp_t mem;
        ex_grp_t  ex;
    } ctl_t;
endpackage

// File: rtl/dec_ctl.sv
module dec_ctl
    import dec_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output ctl_t            ctl
);
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_ALU: begin
                ctl.wb.reg_wr   = 1'b1;
                ctl.ex.dst_sel  = 1'b1;
                ctl.ex.alu_op   = 2'b10;
            end
            OP_LOAD: begin
                ctl.wb.reg_wr     = 1'b1;
                ctl.wb.mem_to_reg = 1'b1;
                ctl.mem.mem_rd    = 1'b1;
                ctl.ex.alu_imm    = 1'b1;
            end
            OP_STORE: begin
                ctl.mem.mem_wr = 1'b1;
                ctl.ex.alu_imm = 1'b1;
            end
            OP_BEQ: begin
                ctl.mem.branch = 1'b1;
                ctl.ex.alu_op  = 2'b01;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/dec_regs.sv
module dec_regs #(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr [2],
    output logic [DW-1:0] rd_data [2],
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    localparam int unsigned NREG = 1 << AW;

    logic [DW-1:0] mem [NREG];
    logic          wr_ok;

    assign wr_ok = wr_en && (wr_addr != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0)
                rd_data[p] = '0;
            else if (wr_ok && (wr_addr == rd_addr[p]))
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_addr[p]];
        end
    end
endmodule

// File: rtl/dec_sext.sv
module dec_sext #(
    parameter int unsigned IW = 16,
    parameter int unsigned OW = 32
) (
    input  logic [IW-1:0] imm_in,
    output logic [OW-1:0] imm_out
);
    localparam int unsigned EXT = OW - IW;
    assign imm_out = {{EXT{imm_in[IW-1]}}, imm_in};
endmodule

// File: rtl/dec_pipe.sv
module dec_pipe
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl_d,
    input  logic [XLEN-1:0]   npc_d,
    input  logic [XLEN-1:0]   rs_d,
    input  logic [XLEN-1:0]   rt_d,
    input  logic [XLEN-1:0]   imm_d,
    input  logic [RIDX_W-1:0] rti_d,
    input  logic [RIDX_W-1:0] rdi_d,
    output ctl_t              ctl_q,
    output logic [XLEN-1:0]   npc_q,
    output logic [XLEN-1:0]   rs_q,
    output logic [XLEN-1:0]   rt_q,
    output logic [XLEN-1:0]   imm_q,
    output logic [RIDX_W-1:0] rti_q,
    output logic [RIDX_W-1:0] rdi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            npc_q <= '0;
            rs_q  <= '0;
            rt_q  <= '0;
            imm_q <= '0;
            rti_q <= '0;
            rdi_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            npc_q <= npc_d;
            rs_q  <= rs_d;
            rt_q  <= rt_d;
            imm_q <= imm_d;
            rti_q <= rti_d;
            rdi_q <= rdi_d;
        end
    end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   ifid_instr,
    input  logic [XLEN-1:0]   ifid_npc,
    input  logic              wb_we,
    input  logic [RIDX_W-1:0] wb_addr,
    input  logic [XLEN-1:0]   wb_data,
    output logic [1:0]        ex_wb_ctl,
    output logic [2:0]        ex_mem_ctl,
    output logic [3:0]        ex_ex_ctl,
    output logic [XLEN-1:0]   ex_npc,
    output logic [XLEN-1:0]   ex_rs_val,
    output logic [XLEN-1:0]   ex_rt_val,
    output logic [XLEN-1:0]   ex_imm,
    output logic [RIDX_W-1:0] ex_rt_idx,
    output logic [RIDX_W-1:0] ex_rd_idx
);
    ctl_t              ctl_d, ctl_q;
    logic [RIDX_W-1:0] raddr [2];
    logic [XLEN-1:0]   rdata [2];
    logic [XLEN-1:0]   imm_x;

    assign raddr[0] = ifid_instr[25:21];
    assign raddr[1] = ifid_instr[20:16];

    dec_ctl u_ctl (
        .opcode (ifid_instr[31:26]),
        .ctl    (ctl_d)
    );

    dec_regs #(.DW(XLEN), .AW(RIDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (raddr),
        .rd_data (rdata),
        .wr_en   (wb_we),
        .wr_addr (wb_addr),
        .wr_data (wb_data)
    );

    dec_sext #(.IW(IMM_W), .OW(XLEN)) u_sext (
        .imm_in  (ifid_instr[15:0]),
        .imm_out (imm_x)
    );

    dec_pipe u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_d (ctl_d),
        .npc_d (ifid_npc),
        .rs_d  (rdata[0]),
        .rt_d  (rdata[1]),
        .imm_d (imm_x),
        .rti_d (ifid_instr[20:16]),
        .rdi_d (ifid_instr[15:11]),
        .ctl_q (ctl_q),
        .npc_q (ex_npc),
        .rs_q  (ex_rs_val),
        .rt_q  (ex_rt_val),
        .imm_q (ex_imm),
        .rti_q (ex_rt_idx),
        .rdi_q (ex_rd_idx)
    );

    assign ex_wb_ctl  = ctl_q.wb;
    assign ex_mem_ctl = ctl_q.mem;
    assign ex_ex_ctl  = ctl_q.ex;
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ifid_instr,
    input logic [31:0] ifid_npc,
    input logic        wb_we,
    input logic [4:0]  wb_addr,
    input logic [31:0] wb_data,
    input logic [1:0]  ex_wb_ctl,
    input logic [2:0]  ex_mem_ctl,
    input logic [3:0]  ex_ex_ctl,
    input logic [31:0] ex_npc,
    input logic [31:0] ex_rs_val,
    input logic [31:0] ex_rt_val,
    input logic [31:0] ex_imm,
    input logic [4:0]  ex_rt_idx,
    input logic [4:0]  ex_rd_idx
);
    // R6
    nop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[31:26] == 6'b100000) |=>
        (ex_wb_ctl == 2'b00 && ex_mem_ctl == 3'b000 && ex_ex_ctl == 4'b0000));

    // R6
    mem_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ex_mem_ctl));

    // R10
    r0_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_instr[25:21] == 5'd0) |=> (ex_rs_val == 32'd0));

    // R9
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_addr != 5'd0 && wb_addr == ifid_instr[20:16]) |=>
        (ex_rt_val == $past(wb_data)));

    // R11
    sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ex_imm[15:0] == $past(ifid_instr[15:0]) &&
                  ex_imm[31:16] == {16{ex_imm[15]}}));

    // R12
    fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ex_npc == $past(ifid_npc) &&
                  ex_rt_idx == $past(ifid_instr[20:16]) &&
                  ex_rd_idx == $past(ifid_instr[15:11])));
endmodule

bind dec_stage dec_stage_chk u_chk (.*);

// File: tb/dec_stage_tb.sv
module dec_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ifid_instr = '0;
    logic [31:0] ifid_npc = '0;
    logic        wb_we = 1'b0;
    logic [4:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic [1:0]  ex_wb_ctl;
    logic [2:0]  ex_mem_ctl;
    logic [3:0]  ex_ex_ctl;
    logic [31:0] ex_npc, ex_rs_val, ex_rt_val, ex_imm;
    logic [4:0]  ex_rt_idx, ex_rd_idx;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dec_stage u_dut (
        .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .ifid_npc(ifid_npc),
        .wb_we(wb_we), .wb_addr(wb_addr), .wb_data(wb_data),
        .ex_wb_ctl(ex_wb_ctl), .ex_mem_ctl(ex_mem_ctl), .ex_ex_ctl(ex_ex_ctl),
        .ex_npc(ex_npc), .ex_rs_val(ex_rs_val), .ex_rt_val(ex_rt_val),
        .ex_imm(ex_imm), .ex_rt_idx(ex_rt_idx), .ex_rd_idx(ex_rd_idx)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                       logic [4:0] rd, logic [10:0] lo);
        return {op, rs, rt, rd, lo};
    endfunction

    // drive at a falling edge, inspect at the next falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 ctl", {23'd0, ex_wb_ctl, ex_mem_ctl, ex_ex_ctl}, 32'd0);
        chk("R1 npc", ex_npc, 32'd0);
        chk("R1 rs|rt|imm", ex_rs_val | ex_rt_val | ex_imm, 32'd0);
        chk("R1 idx", {22'd0, ex_rt_idx, ex_rd_idx}, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_decode(string tag, logic [5:0] op, logic [1:0] wb,
                            logic [2:0] mm, logic [3:0] ex);
        ifid_instr = mk(op, 5'd0, 5'd0, 5'd0, 11'd0);
        step();
        chk({tag, " wb"}, {30'd0, ex_wb_ctl}, {30'd0, wb});
        chk({tag, " mem"}, {29'd0, ex_mem_ctl}, {29'd0, mm});
        chk({tag, " ex"}, {28'd0, ex_ex_ctl}, {28'd0, ex});
    endtask

    task automatic t_write_read();
        wb_we = 1'b1; wb_addr = 5'd5; wb_data = 32'hDEADBEEF;
        ifid_instr = mk(6'b100000, 5'd0, 5'd0, 5'd0, 11'd0);
        step();
        wb_we = 1'b1; wb_addr = 5'd9; wb_data = 32'h0BADF00D;
        step();
        wb_we = 1'b0;
        ifid_instr = mk(6'b000000, 5'd5, 5'd9, 5'd0, 11'd0);
        step();
        chk("R7 R8 rs read", ex_rs_val, 32'hDEADBEEF);
        chk("R7 R8 rt read", ex_rt_val, 32'h0BADF00D);
    endtask

    task automatic t_bypass();
        wb_we = 1'b1; wb_addr = 5'd7; wb_data = 32'h13579BDF;
        ifid_instr = mk(6'b000000, 5'd7, 5'd7, 5'd0, 11'd0);
        step();
        wb_we = 1'b0;
        chk("R9 rs bypass", ex_rs_val, 32'h13579BDF);
        chk("R9 rt bypass", ex_rt_val, 32'h13579BDF);
    endtask

    task automatic t_r0();
        wb_we = 1'b1; wb_addr = 5'd0; wb_data = 32'hFFFF1234;
        ifid_instr = mk(6'b000000, 5'd0, 5'd0, 5'd0, 11'd0);
        step();
        wb_we = 1'b0;
        chk("R10 r0 same cycle", ex_rs_val | ex_rt_val, 32'd0);
        step();
        chk("R10 r0 later", ex_rs_val | ex_rt_val, 32'd0);
    endtask

    task automatic t_sext();
        ifid_instr = {16'hA5A5, 16'h8001};
        step();
        chk("R11 negative", ex_imm, 32'hFFFF8001);
        ifid_instr = {16'h5A5A, 16'h7FFF};
        step();
        chk("R11 positive", ex_imm, 32'h00007FFF);
    endtask

    task automatic t_fields();
        ifid_npc = 32'h0000_0404;
        ifid_instr = mk(6'b000000, 5'd3, 5'd17, 5'd30, 11'h2A);
        step();
        chk("R12 npc", ex_npc, 32'h0000_0404);
        chk("R12 rt idx", {27'd0, ex_rt_idx}, 32'd17);
        chk("R12 rd idx", {27'd0, ex_rd_idx}, 32'd30);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        t_reset();
        step();
        t_decode("R2 rtype", 6'b000000, 2'b10, 3'b000, 4'b1100);
        t_decode("R3 load",  6'b100011, 2'b11, 3'b010, 4'b0001);
        t_decode("R4 store", 6'b101011, 2'b00, 3'b001, 4'b0001);
        t_decode("R5 branch",6'b000100, 2'b00, 3'b100, 4'b0010);
        t_decode("R6 nop",   6'b100000, 2'b00, 3'b000, 4'b0000);
        t_decode("R6 other", 6'b111111, 2'b00, 3'b000, 4'b0000);
        t_write_read();
        t_bypass();
        t_r0();
        t_sext();
        t_fields();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule